// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

The sequencer runs one machine cycle on a shared address/data bus. The cycle passes through the states T1, T2 and T3, then zero or more wait states TW, then T4. The core presents a request: read or write, memory or I/O space, a 20-bit address, a word/byte flag, write data and a three-bit status code. The block latches the request and then drives the address latch strobe, the read strobe, the data-enable window, the transfer direction, the space select and the upper-lane enable. Separate output enables model the tristate pads. A slow target stretches the cycle by holding `ready_in` low. At the end of the cycle the block returns the read data, steered to the right byte lane, and a one-cycle `done` pulse.

A second bus master asks for the bus through `hold_req`. The sequencer grants it only between cycles. A cycle already in progress runs to its T4 first. While the grant is active, every tristate output floats. The only exception is the address latch strobe, which is always driven and held low.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the outputs read `ale`=0, `rd_n`=1, `den`=0, `bhe_n`=1, `done`=0, `hold_ack`=0, `ctl_oe`=1, `dt_r`=0, `m_io`=0 and `rdata`=0.
- R2: A request accepted in an idle cycle starts T1 on the next cycle. In T1, `ale`=1, `ad_oe`=1 and `ad_out` carries address bits 15:0. With no wait states, `done` is high for exactly one cycle, three cycles after T1 (in T4).
- R3: In T1, `a_hi_out` carries address bits 19:16 for a memory cycle and is 0 for an I/O cycle. From T2 through T4 it carries {0, status[2:0]}.
- R4: `bhe_n` is low from T1 through T4 whenever the upper lane (bits 15:8) is used. That is the case for a word access (`req_word`=1, address even) and for a byte access at an odd address. A byte access at an even address uses the lower lane and keeps `bhe_n` high.
- R5: `rd_n` is low in T2, T3 and every TW of a read cycle, and stays high in write cycles.
- R6: `den` rises at the falling clock edge inside T2 and falls at the falling clock edge inside T4. It is therefore high in the second half of T2, in T3 and TW, and in the first half of T4.
- R7: `dt_r` is 1 for a write and 0 for a read. `m_io` is 1 for memory and 0 for I/O. Both take their value in T1 and hold it until the next request is accepted.
- R8: Each cycle in which `ready_in` is sampled low at the end of T3 or TW adds one TW state, which delays T4 and `done` by one cycle.
- R9: Read data is captured at the end of the last T3/TW. A word read returns bus bits 15:0. A byte read returns the byte right-aligned with zero upper bits, taken from bus bits 15:8 at an odd address and from bits 7:0 at an even address. A write leaves `rdata` unchanged.
- R10: In a write cycle, `ad_oe` stays 1 from T2 through T4. `ad_out` carries the write data for a word, or the low write byte copied into both lanes for a byte. In a read cycle, `ad_oe` is 0 from T2 through T4.
- R11: An idle cycle with `hold_req`=1 gives `hold_ack`=1 on the next cycle, with `ad_oe`=0, `ctl_oe`=0 and `ale`=0. No request starts while the grant is held. A `hold_req` raised during a cycle lets that cycle finish with `ctl_oe`=1, and `hold_ack` follows directly after T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted in an idle cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| req_stat | input | 3 | Status code shown on the upper lines after T1 |
| ready_in | input | 1 | Target ready, sampled at the end of T3/TW |
| hold_req | input | 1 | Another master requests the bus |
| ad_in | input | 16 | Value seen on the shared address/data lines |
| ad_out | output | 16 | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Output enable of the address/data lines |
| a_hi_out | output | 4 | Upper address / status lines |
| ctl_oe | output | 1 | Output enable of control and upper lines |
| ale | output | 1 | Address latch strobe, never floated |
| rd_n | output | 1 | Read strobe, active low |
| den | output | 1 | Data transceiver enable, active high |
| dt_r | output | 1 | Direction: 1 transmit, 0 receive |
| m_io | output | 1 | Space select: 1 memory, 0 I/O |
| bhe_n | output | 1 | Upper-lane enable, active low |
| hold_ack | output | 1 | Bus granted to the other master |
| done | output | 1 | One-cycle end-of-cycle pulse in T4 |
| rdata | output | 16 | Lane-aligned read data |

## Verification
The checker watches several properties on every clock. It confirms that all pads float while the grant is held, and that the strobe only appears with the address driven. It checks that I/O cycles put zeros on the upper lines in T1. It confirms that the read strobe only appears while the bus is receiving and released, and that a low ready keeps the read strobe low. It also checks that `ale` and `done` are single-cycle pulses and that `den` is never high during T1. The half-cycle position of `den`, the lane steering of read and write data, the count of inserted wait states and the ordering of a grant behind a running cycle are timing and data relations. Only the bench sweeps show these: they cover every space, direction, access width, address parity and wait count from 0 to 3.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5,
      ST_HOLD = 3'd6
   } bus_st_e;

   function automatic logic st_in_data(input bus_st_e s);
      return (s == ST_T2) || (s == ST_T3) || (s == ST_TW) || (s == ST_T4);
   endfunction

   function automatic logic st_in_cycle(input bus_st_e s);
      return (s == ST_T1) || st_in_data(s);
   endfunction

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
   import mbs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    ready_in,
   input  logic    hold_req,
   output bus_st_e st_o,
   output logic    accept_o,
   output logic    capture_o
);

   bus_st_e st_q, st_nx;

   always_comb begin
      st_nx = st_q;
      case (st_q)
         ST_IDLE: begin
            if (hold_req)       st_nx = ST_HOLD;
            else if (req_valid) st_nx = ST_T1;
         end
         ST_T1:   st_nx = ST_T2;
         ST_T2:   st_nx = ST_T3;
         ST_T3,
         ST_TW:   st_nx = ready_in ? ST_T4 : ST_TW;
         ST_T4:   st_nx = hold_req ? ST_HOLD : ST_IDLE;
         ST_HOLD: if (!hold_req) st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_nx;
   end

   assign st_o      = st_q;
   assign accept_o  = (st_q == ST_IDLE) && !hold_req && req_valid;
   assign capture_o = ((st_q == ST_T3) || (st_q == ST_TW)) && ready_in;

endmodule

// File: rtl/mbs_lane.sv
module mbs_lane #(
   parameter int DW       = 16,
   parameter bit RD_ALIGN = 1'b1
) (
   input  logic          word,
   input  logic          odd,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] rbus,
   output logic          hi_en_n,
   output logic [DW-1:0] wlanes,
   output logic [DW-1:0] rword
);

   localparam int LW = DW / 2;

   assign hi_en_n = !(word || odd);
   assign wlanes  = word ? wdata : {wdata[LW-1:0], wdata[LW-1:0]};

   generate
      if (RD_ALIGN) begin : g_right
         always_comb begin
            if (word)     rword = rbus;
            else if (odd) rword = {{LW{1'b0}}, rbus[DW-1:LW]};
            else          rword = {{LW{1'b0}}, rbus[LW-1:0]};
         end
      end else begin : g_inplace
         always_comb begin
            if (word)     rword = rbus;
            else if (odd) rword = {rbus[DW-1:LW], {LW{1'b0}}};
            else          rword = {{LW{1'b0}}, rbus[LW-1:0]};
         end
      end
   endgenerate

endmodule

// File: rtl/mbs_den.sv
module mbs_den (
   input  logic clk,
   input  logic rst_n,
   input  logic win_on,
   output logic den_o
);

   // Updated on the falling edge: the enable opens and closes half a
   // cycle after the state that requests it.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) den_o <= 1'b0;
      else        den_o <= win_on;
   end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int AW       = 20,
   parameter int DW       = 16,
   parameter bit RD_ALIGN = 1'b1,
   localparam int HI_W    = AW - DW,
   localparam int ST_W    = HI_W - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic            req_mem,
   input  logic            req_word,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   input  logic [ST_W-1:0] req_stat,
   input  logic            ready_in,
   input  logic            hold_req,
   input  logic [DW-1:0]   ad_in,
   output logic [DW-1:0]   ad_out,
   output logic            ad_oe,
   output logic [HI_W-1:0] a_hi_out,
   output logic            ctl_oe,
   output logic            ale,
   output logic            rd_n,
   output logic            den,
   output logic            dt_r,
   output logic            m_io,
   output logic            bhe_n,
   output logic            hold_ack,
   output logic            done,
   output logic [DW-1:0]   rdata
);

   generate
      if (DW % 16 != 0 || DW < 16) begin : g_bad_dw
         $error("DW must be a positive multiple of 16");
      end
      if (HI_W < 2) begin : g_bad_aw
         $error("AW must exceed DW by at least 2");
      end
   endgenerate

   bus_st_e st;
   logic    accept, capture;

   logic [AW-1:0]   cap_addr;
   logic [DW-1:0]   cap_wdata;
   logic [ST_W-1:0] cap_stat;
   logic            cap_write, cap_mem, cap_word;
   logic            m_io_q, dt_r_q;
   logic [DW-1:0]   rdata_q;

   logic            hi_en_n;
   logic [DW-1:0]   wlanes, rword;

   mbs_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .ready_in  (ready_in),
      .hold_req  (hold_req),
      .st_o      (st),
      .accept_o  (accept),
      .capture_o (capture)
   );

   mbs_lane #(.DW(DW), .RD_ALIGN(RD_ALIGN)) u_lane (
      .word    (cap_word),
      .odd     (cap_addr[0]),
      .wdata   (cap_wdata),
      .rbus    (ad_in),
      .hi_en_n (hi_en_n),
      .wlanes  (wlanes),
      .rword   (rword)
   );

   mbs_den u_den (
      .clk    (clk),
      .rst_n  (rst_n),
      .win_on ((st == ST_T2) || (st == ST_T3) || (st == ST_TW)),
      .den_o  (den)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr  <= '0;
         cap_wdata <= '0;
         cap_stat  <= '0;
         cap_write <= 1'b0;
         cap_mem   <= 1'b0;
         cap_word  <= 1'b0;
         m_io_q    <= 1'b0;
         dt_r_q    <= 1'b0;
      end else if (accept) begin
         cap_addr  <= req_addr;
         cap_wdata <= req_wdata;
         cap_stat  <= req_stat;
         cap_write <= req_write;
         cap_mem   <= req_mem;
         cap_word  <= req_word;
         m_io_q    <= req_mem;
         dt_r_q    <= req_write;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rdata_q <= '0;
      else if (capture && !cap_write)  rdata_q <= rword;
   end

   always_comb begin
      if (st == ST_T1)
         a_hi_out = cap_mem ? cap_addr[AW-1:DW] : '0;
      else
         a_hi_out = {1'b0, cap_stat};
   end

   assign ad_out   = (st == ST_T1) ? cap_addr[DW-1:0] : wlanes;
   assign ad_oe    = (st == ST_T1) || (cap_write && st_in_data(st));
   assign hold_ack = (st == ST_HOLD);
   assign ctl_oe   = !hold_ack;
   assign ale      = (st == ST_T1);
   assign rd_n     = !(!cap_write &&
                       ((st == ST_T2) || (st == ST_T3) || (st == ST_TW)));
   assign bhe_n    = st_in_cycle(st) ? hi_en_n : 1'b1;
   assign dt_r     = dt_r_q;
   assign m_io     = m_io_q;
   assign done     = (st == ST_T4);
   assign rdata    = rdata_q;

endmodule

// File: rtl/mbs_chk.sv
module mbs_chk #(
   parameter int HI_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ale,
   input logic            ad_oe,
   input logic            ctl_oe,
   input logic            hold_ack,
   input logic            rd_n,
   input logic            ready_in,
   input logic            done,
   input logic            m_io,
   input logic            dt_r,
   input logic            den,
   input logic [HI_W-1:0] a_hi_out
);

   AST_HOLD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> (!ad_oe && !ctl_oe && !ale));                 // R11

   AST_ALE_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe && ctl_oe));                                // R2

   AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);                                             // R2

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                           // R2

   AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && !m_io) |-> (a_hi_out == '0));                      // R3

   AST_READ_RECEIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (!dt_r && !ad_oe));                              // R5

   AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !ready_in) |=> !rd_n);                           // R8

   AST_DEN_CLOSED_T1: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> !den);                                             // R6

endmodule

bind mux_bus_seq mbs_chk #(.HI_W(HI_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ale      (ale),
   .ad_oe    (ad_oe),
   .ctl_oe   (ctl_oe),
   .hold_ack (hold_ack),
   .rd_n     (rd_n),
   .ready_in (ready_in),
   .done     (done),
   .m_io     (m_io),
   .dt_r     (dt_r),
   .den      (den),
   .a_hi_out (a_hi_out)
);

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [2:0]  req_stat = '0;
   logic        ready_in = 1'b1, hold_req = 1'b0;
   logic [15:0] ad_in = '0;
   logic [15:0] ad_out, rdata;
   logic [3:0]  a_hi_out;
   logic        ad_oe, ctl_oe, ale, rd_n, den, dt_r, m_io, bhe_n, hold_ack, done;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [15:0] prev_rd = '0;

   always #4 clk = ~clk;

   mux_bus_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mem(req_mem), .req_word(req_word), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_stat(req_stat), .ready_in(ready_in),
      .hold_req(hold_req), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .a_hi_out(a_hi_out), .ctl_oe(ctl_oe), .ale(ale), .rd_n(rd_n), .den(den),
      .dt_r(dt_r), .m_io(m_io), .bhe_n(bhe_n), .hold_ack(hold_ack),
      .done(done), .rdata(rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_txn(input bit wr, input bit mem, input bit word,
                          input logic [19:0] addr, input logic [15:0] wd,
                          input logic [2:0] st, input int waits,
                          input logic [15:0] rbus, input int hold_at);
      logic [15:0] exp_rd, exp_wl;
      logic        exp_bhe;
      int          last;
      exp_bhe = !(word || addr[0]);
      exp_wl  = word ? wd : {wd[7:0], wd[7:0]};
      exp_rd  = word ? rbus : (addr[0] ? {8'h00, rbus[15:8]} : {8'h00, rbus[7:0]});
      last    = 3 + waits;
      @(posedge clk); #1;
      req_write = wr; req_mem = mem; req_word = word; req_addr = addr;
      req_wdata = wd; req_stat = st; ad_in = rbus; ready_in = 1'b1;
      req_valid = 1'b1;
      for (int n = 0; n <= last; n++) begin
         @(posedge clk); #1;
         if (n == 0) req_valid = 1'b0;
         ready_in = (n < 2) ? 1'b1 : ((n - 2) >= waits);
         if (n == hold_at) hold_req = 1'b1;
         #1;
         chk("R2 ale", ale, n == 0);
         chk("R2 R8 done", done, n == last);
         chk("R10 ad_oe", ad_oe, (n == 0) || wr);
         if (n == 0)  chk("R2 ad_out addr", ad_out, addr[15:0]);
         else if (wr) chk("R10 ad_out wdata", ad_out, exp_wl);
         if (n == 0)  chk("R3 upper addr", a_hi_out, mem ? addr[19:16] : 4'h0);
         else         chk("R3 upper status", a_hi_out, {1'b0, st});
         chk("R5 R8 rd_n", rd_n, !(!wr && n >= 1 && n <= last - 1));
         chk("R4 bhe_n", bhe_n, exp_bhe);
         chk("R7 dt_r", dt_r, wr);
         chk("R7 m_io", m_io, mem);
         chk("R11 ctl_oe in cycle", ctl_oe, 1'b1);
         chk("R6 den first half", den, n >= 2 && n <= last);
         #4;
         chk("R6 den second half", den, n >= 1 && n <= last - 1);
      end
      @(posedge clk); #2;
      ready_in = 1'b1;
      chk("R2 done cleared", done, 1'b0);
      if (!wr) prev_rd = exp_rd;
      chk("R9 rdata", rdata, prev_rd);
      chk("R11 grant after cycle", hold_ack, hold_at >= 0);
      if (hold_at >= 0) begin
         chk("R11 pads float", {ad_oe, ctl_oe}, 2'b00);
         hold_req = 1'b0;
         @(posedge clk); #2;
         chk("R11 grant released", hold_ack, 1'b0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1 ale", ale, 1'b0);
      chk("R1 rd_n", rd_n, 1'b1);
      chk("R1 den", den, 1'b0);
      chk("R1 bhe_n", bhe_n, 1'b1);
      chk("R1 done", done, 1'b0);
      chk("R1 hold_ack", hold_ack, 1'b0);
      chk("R1 ctl_oe", ctl_oe, 1'b1);
      chk("R1 dt_r m_io", {dt_r, m_io}, 2'b00);
      chk("R1 rdata", rdata, 16'h0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // sweep: direction x space x lane kind x wait count
      for (int wr = 0; wr < 2; wr++)
         for (int mem = 0; mem < 2; mem++)
            for (int kind = 0; kind < 3; kind++)
               for (int ws = 0; ws < 4; ws++) begin
                  logic [19:0] a;
                  logic [15:0] wd, rb;
                  a  = (20'hC35A0 + 20'h11110 * 20'(ws + 4 * kind + 12 * mem)) & 20'hFFFFE;
                  a  = a | 20'(kind == 2);
                  wd = 16'h1234 ^ 16'(ws * 16'h0F0F + kind * 16'h3300 + wr);
                  rb = 16'hBEEF ^ 16'(ws * 16'h0101 + kind * 16'h5A00 + mem);
                  run_txn(wr[0], mem[0], kind == 0, a, wd, 3'(ws + kind + mem),
                          ws, rb, -1);
               end

      // long wait chain on a word read (R8, R9)
      run_txn(1'b0, 1'b1, 1'b1, 20'h7FFFE, 16'h0, 3'd5, 6, 16'hA55A, -1);

      // R11 grant requested in T2 of a running cycle
      run_txn(1'b1, 1'b1, 1'b0, 20'h00013, 16'h00C3, 3'd2, 1, 16'h0, 1);

      // R11 grant from idle, request held off meanwhile
      @(posedge clk); #1;
      hold_req = 1'b1;
      req_write = 1'b0; req_mem = 1'b1; req_word = 1'b1;
      req_addr = 20'h2468A; req_stat = 3'd1;
      req_valid = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         chk("R11 hold_ack", hold_ack, 1'b1);
         chk("R11 float", {ad_oe, ctl_oe}, 2'b00);
         chk("R11 no strobe in grant", ale, 1'b0);
      end
      hold_req = 1'b0;
      @(posedge clk); #2;
      chk("R11 idle after grant", {hold_ack, ale}, 2'b00);
      @(posedge clk); #1;
      req_valid = 1'b0;
      #1;
      chk("R2 T1 after grant", ale, 1'b1);
      chk("R2 addr after grant", ad_out, 16'h468A);
      repeat (5) @(posedge clk);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule